// File: doc/BRIEF.md
# FM Operator Datapath with Algorithm Mixer

This block is the time-multiplexed core of a four-operator-per-voice FM synthesizer with six voices, 24 operator slots in all. Each time the sequencer is stepped it serves one operator slot. It adds that slot's frequency step to the slot's phase accumulator. It then looks up a logarithmic half-wave sine value for the new phase and adds the attenuation for the slot. The sum is converted back to a linear magnitude, and the sign comes from the top phase bit.

The block serves the operators of each voice in turn. When it finishes the last operator of a voice, it forms the voice output. The voice output combines that voice's operator results as selected by a 3-bit algorithm number.

The surrounding logic reads the current slot number from `cur_op` and presents three values for that slot: its phase step, its attenuation, and the control byte of its voice. A global sample-playback control bit can freeze the last voice so that its slots are passed over. Both lookup tables are computed as constants when the design is elaborated.

Top module: `fm_op_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 24 phase accumulators and stored operator results are cleared. `cur_op`, `op_idx`, `op_out`, `ch_idx` and `ch_out` become 0, and `op_valid` and `ch_valid` become 0.
- R2: Each edge with `slot_en` high advances `cur_op` by one, wrapping from 23 to 0. The result for the slot that was served appears on the next cycle with `op_valid` high and `op_idx` equal to that slot. Slot s belongs to voice s/4, at position s%4 within the voice.
- R3: Serving a slot replaces its 20-bit accumulator with (accumulator + `phase_inc`) mod 2^20. The table phase is bits [19:10] of the new value.
- R4: The log-sine table has 512 entries. Entry i is round(−log2(sin(((2i+1)/512)·π/2))·256), which is the attenuation in a format with 8 fraction bits.
- R5: For a 13-bit exponent index x, let f = x[7:0] and n = x[12:8]. The table value is m = round(2^−((f+1)/256)·2048). The exponent output is m shifted left by (2−n) when n < 2, and m shifted right by (n−2) otherwise.
- R6: The operator magnitude is exp(min(logsin(phase[8:0]) + `atten`, 8191)). A sum above 8191 saturates to index 8191.
- R7: `op_out` is the magnitude as a 14-bit two's-complement number, negated when phase bit 9 is set.
- R8: Serving position 3 of a voice also raises `ch_valid` on the next cycle, with `ch_idx` set to the voice number. The algorithm number is `alg_fb[2:0]`, read during that position-3 slot; bits [7:3] have no effect.
- R9: Algorithms 0 to 3 output the position-3 operator alone. Algorithm 4 outputs the sum of positions 3 and 1.
- R10: Algorithms 5 and 6 output the sum of positions 1, 2 and 3. Algorithm 7 outputs the sum of all four positions. `ch_out` is 16-bit signed.
- R11: When `dac_ctrl[7]` is 1, slots 20 to 23 (voice 5) are stepped past without effect: the accumulator holds, and neither `op_valid` nor `ch_valid` is raised. The other bits of `dac_ctrl` have no effect.
- R12: An edge with `slot_en` low changes no accumulator and leaves `cur_op` unchanged. It produces no `op_valid` and no `ch_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Serve the current slot at this edge |
| phase_inc | input | 20 | Phase step for the slot in `cur_op` |
| atten | input | 13 | Attenuation (log domain) for the slot in `cur_op` |
| alg_fb | input | 8 | Voice control byte; bits [2:0] select the algorithm |
| dac_ctrl | input | 8 | Bit 7 freezes voice 5 |
| cur_op | output | 5 | Slot served at the next enabled edge |
| op_valid | output | 1 | `op_out` holds a fresh result |
| op_idx | output | 5 | Slot that produced `op_out` |
| op_out | output | 14 | Signed operator result |
| ch_valid | output | 1 | `ch_out` holds a fresh voice result |
| ch_idx | output | 3 | Voice that produced `ch_out` |
| ch_out | output | 16 | Signed voice result |

## Verification
The hardest cases to reach are the exponent-index saturation and the frozen-voice path. For saturation, the log-sine value and the attenuation must sum past 8191, and that must happen on a phase the accumulator actually reaches. The bench sweeps 48 rounds of all 24 slots. The step values are chosen so that the table phases spread widely. The attenuation patterns rotate through zero, mid-range and values near 8191.

Some rounds set the freeze bit. The bench then checks that a frozen slot's accumulator did not move: in a later round, the slot's output must match a model whose accumulator was also held. A reset in the middle of a round, with `cur_op` not at zero, shows the accumulator clearing in the same way.

// File: rtl/fm_pkg.sv
// Shared sizes and constant-table generators for the FM operator datapath.
// Assumes four operators per voice and a 20-bit phase accumulator whose
// bits [19:10] form the table phase.
package fm_pkg;
    localparam int NUM_CH     = 6;
    localparam int OPS_PER_CH = 4;
    localparam int NUM_OPS    = NUM_CH * OPS_PER_CH;
    localparam int OP_W       = $clog2(NUM_OPS);
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int POS_W      = $clog2(OPS_PER_CH);
    localparam int PHASE_W    = 20;
    localparam int TPH_W      = 10;
    localparam int SIN_AW     = TPH_W - 1;
    localparam int SIN_N      = 1 << SIN_AW;
    localparam int LOGSIN_W   = 12;
    localparam int ATT_W      = 13;
    localparam int EXP_IDX_W  = 13;
    localparam int FRAC_W     = 8;
    localparam int FRAC_N     = 1 << FRAC_W;
    localparam int MANT_W     = 11;
    localparam int OUT_W      = EXP_IDX_W + 1;
    localparam int MIX_W      = OUT_W + 2;
    localparam real HALF_PI   = 1.5707963267948966;

    // Log-attenuation of one half-wave sine point, 8 fraction bits.
    function automatic int logsin_entry(int i);
        real s;
        s = $sin(((2.0 * i + 1.0) / real'(SIN_N)) * HALF_PI);
        return $rtoi(-($ln(s) / $ln(2.0)) * 256.0 + 0.5);
    endfunction

    // Mantissa of the fractional power of two for fraction f.
    function automatic int exp_mant(int f);
        return $rtoi($pow(2.0, -(real'(f) + 1.0) / 256.0) * 2048.0 + 0.5);
    endfunction
endpackage

// File: rtl/fm_logsin_rom.sv
// Half-wave log-sine lookup: maps a 9-bit phase within a half wave to the
// attenuation of the sine there. The contents are elaboration constants.
module fm_logsin_rom
    import fm_pkg::*;
(
    input  logic [SIN_AW-1:0]   addr,
    output logic [LOGSIN_W-1:0] val
);
    logic [LOGSIN_W-1:0] tbl [SIN_N];

    // One constant entry per phase point.
    for (genvar g = 0; g < SIN_N; g++) begin : g_ent
        localparam int V = logsin_entry(g);
        assign tbl[g] = LOGSIN_W'(V);
    end

    assign val = tbl[addr];
endmodule

// File: rtl/fm_exp_rom.sv
// Log-to-linear converter. The low 8 index bits pick a mantissa for the
// fractional power of two, and the high 5 bits give a shift (2 - n).
// Assumes the index is already saturated to 13 bits.
module fm_exp_rom
    import fm_pkg::*;
(
    input  logic [EXP_IDX_W-1:0] idx,
    output logic [EXP_IDX_W-1:0] mag
);
    localparam int IP_W = EXP_IDX_W - FRAC_W;

    logic [MANT_W-1:0]    mant_tbl [FRAC_N];
    logic [MANT_W-1:0]    mant;
    logic [EXP_IDX_W-1:0] wide;
    logic [IP_W-1:0]      ip;

    // Constant mantissa per fraction value.
    for (genvar g = 0; g < FRAC_N; g++) begin : g_mant
        localparam int M = exp_mant(g);
        assign mant_tbl[g] = MANT_W'(M);
    end

    assign mant = mant_tbl[idx[FRAC_W-1:0]];
    assign ip   = idx[EXP_IDX_W-1:FRAC_W];
    assign wide = EXP_IDX_W'(mant);

    // Integer part decodes to a left shift below 2 and a right shift above.
    always_comb begin
        if (ip < IP_W'(2)) mag = wide << (IP_W'(2) - ip);
        else               mag = wide >> (ip - IP_W'(2));
    end

    // R5: from integer part 13 up, the shift empties the mantissa.
    always_comb begin
        if (ip >= IP_W'(13))
            a_r5_deep_index_zero: assert (mag == '0);
        a_r5_mag_bound: assert (mag <= EXP_IDX_W'(8168));
    end
endmodule

// File: rtl/fm_alg_mix.sv
// Voice combiner: sums a subset of the four operator results of one voice,
// as chosen by the 3-bit algorithm number. p3 is the last operator served.
module fm_alg_mix
    import fm_pkg::*;
(
    input  logic signed [OUT_W-1:0] p0,
    input  logic signed [OUT_W-1:0] p1,
    input  logic signed [OUT_W-1:0] p2,
    input  logic signed [OUT_W-1:0] p3,
    input  logic [2:0]              alg,
    output logic signed [MIX_W-1:0] sum
);
    logic signed [MIX_W-1:0] e0, e1, e2, e3;

    assign e0 = MIX_W'(p0);
    assign e1 = MIX_W'(p1);
    assign e2 = MIX_W'(p2);
    assign e3 = MIX_W'(p3);

    // Choose which operator results reach the output.
    always_comb begin
        unique case (alg)
            3'd4:       sum = e3 + e1;
            3'd5, 3'd6: sum = e3 + e2 + e1;
            3'd7:       sum = e3 + e2 + e1 + e0;
            default:    sum = e3;
        endcase
    end

    // R9: the serial algorithms never let the earlier operators through.
    always_comb begin
        if (alg < 3'd4)
            a_r9_serial_passes_last: assert (sum == MIX_W'(p3));
    end
endmodule

// File: rtl/fm_op_mixer.sv
// FM operator datapath for 24 time-shared slots. For each enabled step it
// serves slot cur_op: it advances the phase, does the log-sine and
// exponent lookups, applies the sign and stores the result. At position 3
// of a voice it also forms the voice output. The caller presents phase_inc,
// atten and alg_fb for slot cur_op. dac_ctrl[7] freezes voice 5.
module fm_op_mixer
    import fm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slot_en,
    input  logic [PHASE_W-1:0]      phase_inc,
    input  logic [ATT_W-1:0]        atten,
    input  logic [7:0]              alg_fb,
    input  logic [7:0]              dac_ctrl,
    output logic [OP_W-1:0]         cur_op,
    output logic                    op_valid,
    output logic [OP_W-1:0]         op_idx,
    output logic signed [OUT_W-1:0] op_out,
    output logic                    ch_valid,
    output logic [CH_W-1:0]         ch_idx,
    output logic signed [MIX_W-1:0] ch_out
);
    localparam int SUM_W   = ATT_W + 1;
    localparam int EXP_MAX = (1 << EXP_IDX_W) - 1;

    logic [PHASE_W-1:0]      acc_q [NUM_OPS];
    logic signed [OUT_W-1:0] opv_q [NUM_OPS];

    logic [CH_W-1:0]         ch;
    logic [POS_W-1:0]        pos;
    logic                    skip, upd;
    logic [PHASE_W-1:0]      acc_next;
    logic [TPH_W-1:0]        tphase;
    logic [LOGSIN_W-1:0]     sin_v;
    logic [SUM_W-1:0]        idx_sum;
    logic [EXP_IDX_W-1:0]    exp_idx;
    logic [EXP_IDX_W-1:0]    mag;
    logic signed [OUT_W-1:0] op_new;
    logic signed [MIX_W-1:0] mix;
    logic [OP_W-1:0]         base;
    logic                    unused_cfg_bits;

    assign unused_cfg_bits = ^{alg_fb[7:3], dac_ctrl[6:0]};

    // Slot decode: voice number, position, and whether the voice is frozen.
    assign ch   = CH_W'(cur_op >> POS_W);
    assign pos  = cur_op[POS_W-1:0];
    assign base = OP_W'(ch) << POS_W;
    assign skip = dac_ctrl[7] && (ch == CH_W'(NUM_CH - 1));
    assign upd  = slot_en && !skip;

    // Phase advance and table phase from the top accumulator bits.
    assign acc_next = acc_q[cur_op] + phase_inc;
    assign tphase   = acc_next[PHASE_W-1 -: TPH_W];

    fm_logsin_rom u_logsin (
        .addr (tphase[SIN_AW-1:0]),
        .val  (sin_v)
    );

    // Add attenuation in the log domain, saturating the exponent index.
    assign idx_sum = SUM_W'(sin_v) + SUM_W'(atten);
    assign exp_idx = (idx_sum > SUM_W'(EXP_MAX)) ? EXP_IDX_W'(EXP_MAX)
                                                 : idx_sum[EXP_IDX_W-1:0];

    fm_exp_rom u_exp (
        .idx (exp_idx),
        .mag (mag)
    );

    // Second half of the wave is negative.
    assign op_new = tphase[TPH_W-1] ? -$signed({1'b0, mag})
                                    :  $signed({1'b0, mag});

    fm_alg_mix u_mix (
        .p0  (opv_q[base]),
        .p1  (opv_q[base + OP_W'(1)]),
        .p2  (opv_q[base + OP_W'(2)]),
        .p3  (op_new),
        .alg (alg_fb[2:0]),
        .sum (mix)
    );

    // Slot sequencer: steps through all slots and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_op <= '0;
        else if (slot_en)
            cur_op <= (cur_op == OP_W'(NUM_OPS - 1)) ? '0 : cur_op + OP_W'(1);
    end

    // Per-slot state: accumulator and last operator result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OPS; i++) begin
                acc_q[i] <= '0;
                opv_q[i] <= '0;
            end
        end else if (upd) begin
            acc_q[cur_op] <= acc_next;
            opv_q[cur_op] <= op_new;
        end
    end

    // Output registers for operator and voice results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_idx   <= '0;
            op_out   <= '0;
            ch_valid <= 1'b0;
            ch_idx   <= '0;
            ch_out   <= '0;
        end else begin
            op_valid <= upd;
            ch_valid <= upd && (pos == POS_W'(OPS_PER_CH - 1));
            if (upd) begin
                op_idx <= cur_op;
                op_out <= op_new;
                if (pos == POS_W'(OPS_PER_CH - 1)) begin
                    ch_idx <= ch;
                    ch_out <= mix;
                end
            end
        end
    end

    // R2: the sequencer wraps after the last slot.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && cur_op == OP_W'(NUM_OPS - 1)) |=> (cur_op == '0));

    // R2: a served slot reports its own index one cycle later.
    a_r2_index_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_idx == $past(cur_op)));

    // R3: the stored accumulator moved by exactly the presented step.
    a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (acc_q[op_idx] == $past(acc_q[cur_op]) + $past(phase_inc)));

    // R8: a voice result only follows the last position of a voice.
    a_r8_voice_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (op_valid && op_idx[POS_W-1:0] == POS_W'(OPS_PER_CH - 1)
                      && OP_W'(ch_idx) == (op_idx >> POS_W)));

    // R11: frozen voice slots produce nothing.
    a_r11_frozen_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && dac_ctrl[7] && cur_op >= OP_W'(NUM_OPS - OPS_PER_CH))
        |=> (!op_valid && !ch_valid));

    // R12: an idle edge holds the sequencer and emits nothing.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> (!op_valid && !ch_valid && $stable(cur_op)));
endmodule

// File: tb/fm_op_mixer_tb.sv
`timescale 1ns/1ps
module fm_op_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0;
    logic [19:0] phase_inc = '0;
    logic [12:0] atten = '0;
    logic [7:0]  alg_fb = '0;
    logic [7:0]  dac_ctrl = '0;
    logic [4:0]  cur_op;
    logic        op_valid;
    logic [4:0]  op_idx;
    logic signed [13:0] op_out;
    logic        ch_valid;
    logic [2:0]  ch_idx;
    logic signed [15:0] ch_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int acc_m [24];
    int opm   [24];

    always #2.5 clk = ~clk;

    fm_op_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .phase_inc(phase_inc),
        .atten(atten), .alg_fb(alg_fb), .dac_ctrl(dac_ctrl), .cur_op(cur_op),
        .op_valid(op_valid), .op_idx(op_idx), .op_out(op_out),
        .ch_valid(ch_valid), .ch_idx(ch_idx), .ch_out(ch_out)
    );

    task automatic chk(input int act, input int exp_v, input string tag);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    function automatic int sin_ref(int i);
        real s;
        s = $sin(((2.0 * i + 1.0) / 512.0) * 1.5707963267948966);
        return $rtoi(-($ln(s) / $ln(2.0)) * 256.0 + 0.5);
    endfunction

    function automatic int exp_ref(int x);
        int f, n, m;
        f = x % 256;
        n = x / 256;
        m = $rtoi($pow(2.0, -(real'(f) + 1.0) / 256.0) * 2048.0 + 0.5);
        if (n < 2) return m << (2 - n);
        return m >> (n - 2);
    endfunction

    task automatic check_reset_state();
        chk(int'(cur_op), 0, "R1 cur_op");
        chk(int'(op_valid), 0, "R1 op_valid");
        chk(int'(ch_valid), 0, "R1 ch_valid");
        chk(int'(op_out), 0, "R1 op_out");
        chk(int'(ch_out), 0, "R1 ch_out");
        chk(int'(op_idx) + int'(ch_idx), 0, "R1 indices");
        for (int i = 0; i < 24; i++) begin
            acc_m[i] = 0;
            opm[i] = 0;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bop;
        bop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        for (int s = 0; s < 48 * 24; s++) begin
            int r, k, ch, pos, alg, att, inc, ph, idx, mag, val, sum_e;
            bit dac_on, skip;
            r = s / 24;
            k = bop;
            ch = k / 4;
            pos = k % 4;

            // Mid-round reset with the sequencer away from slot 0 (R1).
            if (s == 590) begin
                rst_n = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check_reset_state();
                rst_n = 1'b1;
                bop = 0;
                k = 0; ch = 0; pos = 0;
            end

            // Idle edge: nothing advances (R12).
            if (r % 5 == 1 && k == 10) begin
                slot_en = 1'b0;
                @(posedge clk);
                @(negedge clk);
                chk(int'(op_valid), 0, "R12 op_valid idle");
                chk(int'(ch_valid), 0, "R12 ch_valid idle");
                chk(int'(cur_op), k, "R12 cur_op held");
            end

            inc = (((k * 97 + r * 13 + 5) & 1023) << 10) | ((k * 31 + r * 7) & 1023);
            case (r % 6)
                0: att = 0;
                1: att = (k * 41) % 512;
                2: att = 2000 + k * 100;
                3: att = 8191 - k * 5;
                4: att = (r * 211 + k * 53) % 4096;
                default: att = 600 + k;
            endcase
            alg = (r + ch) % 8;
            dac_on = (r % 4 == 2);
            skip = dac_on && (k >= 20);

            phase_inc = 20'(inc);
            atten = 13'(att);
            alg_fb = {5'((r * 7 + k) & 31), 3'(alg)};
            dac_ctrl = dac_on ? (8'h80 | 8'(r & 127)) : 8'(r & 127);
            chk(int'(cur_op), k, "R2 cur_op before step");
            slot_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slot_en = 1'b0;

            if (skip) begin
                chk(int'(op_valid), 0, "R11 frozen op_valid");
                chk(int'(ch_valid), 0, "R11 frozen ch_valid");
            end else begin
                acc_m[k] = (acc_m[k] + inc) & 20'hFFFFF;
                ph = (acc_m[k] >> 10) & 1023;                 // R3
                idx = sin_ref(ph & 511) + att;                // R4
                if (idx > 8191) idx = 8191;                   // R6 saturation
                mag = exp_ref(idx);                           // R5
                val = (ph >= 512) ? -mag : mag;               // R7
                opm[k] = val;
                chk(int'(op_valid), 1, "R2 op_valid");
                chk(int'(op_idx), k, "R2 op_idx");
                chk(int'(op_out), val, "R6 R7 op_out");
                if (pos == 3) begin
                    case (alg)
                        4: sum_e = opm[k] + opm[k - 2];                            // R9
                        5, 6: sum_e = opm[k] + opm[k - 1] + opm[k - 2];            // R10
                        7: sum_e = opm[k] + opm[k - 1] + opm[k - 2] + opm[k - 3];  // R10
                        default: sum_e = opm[k];                                   // R9
                    endcase
                    chk(int'(ch_valid), 1, "R8 ch_valid");
                    chk(int'(ch_idx), ch, "R8 ch_idx");
                    chk(int'(ch_out), sum_e, "R9 R10 ch_out");
                end else begin
                    chk(int'(ch_valid), 0, "R8 ch_valid mid-voice");
                end
            end
            bop = (bop == 23) ? 0 : bop + 1;
        end

        chk(int'(cur_op), bop, "R2 final cur_op");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule